// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is one DMA channel that works through a chain of descriptors kept in system memory. Software sets a destination start address, then writes the address of the first descriptor, which starts the channel. For each descriptor the channel reads four words, moves the requested number of words from the source to the destination, writes the descriptor's control-A word back with the done flag set, and follows the descriptor's link to the next one. The chain ends when that link is zero.

The destination address comes from the setup register only. It is never taken from a descriptor, so data from all buffers lands in one contiguous destination run, either rising or falling. Each finished buffer gives a one-cycle interrupt pulse and sets a pending bit that software clears. The end of the chain gives a separate one-cycle pulse. The channel does not wait for software to clear the pending bit before it starts the next descriptor.

Top module: `lldma_chan`

## Requirements
- R1: While reset is applied and after it is released, with no setup write yet, `busy`, `mem_req`, `buf_irq`, `chain_irq` and `buf_pend` are all 0.
- R2: A setup write to offset 0 loads the destination address. A setup write to offset 1 loads the first descriptor's byte address and starts the channel. Both writes are ignored while `busy` is 1.
- R3: A descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12, read in that order: source address, control A (remaining word count in bits [15:0], done flag in bit 31), control B (source mode in bits [1:0], destination mode in bits [5:4]), next-descriptor byte address.
- R4: Each counted word is read from the source address and then written to the destination address. A buffer with a count of 0 moves no data.
- R5: In each mode field, 0 steps the address up by 4 bytes per word, 1 steps it down by 4, and 2 leaves it fixed.
- R6: The destination address is never loaded from a descriptor. The next buffer continues from the address after the last word of the previous buffer.
- R7: At the end of each buffer the only descriptor word written is control A, at the address it was read from. Its count field reads 0, bits [30:16] are unchanged, and no other memory outside the destination run is written.
- R8: The done flag is cleared when control A is loaded and stays clear while words are moved. It is set in the written-back word.
- R9: With memory that acknowledges every request in the cycle it is made, a buffer of n words keeps the channel busy for 4 + 2n + 1 cycles, and the next descriptor fetch starts in the cycle right after the write-back, whether or not the pending bit is set.
- R10: When the control-A write-back completes and the descriptor's next pointer is 0, `chain_irq` is 1 for exactly one cycle and `busy` drops at the same time.
- R11: `buf_irq` is 1 for exactly one cycle after each control-A write-back, and `buf_pend` is set at the same time. `buf_pend` stays set until a setup write to offset 2 with bit 0 at 1. A new set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Setup write strobe |
| cfg_addr | input | 2 | Setup offset: 0 destination, 1 first descriptor and start, 2 clear pending |
| cfg_wdata | input | 32 | Setup write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Channel is running a chain |
| buf_irq | output | 1 | One-cycle pulse per finished buffer |
| buf_pend | output | 1 | Sticky buffer-finished status |
| chain_irq | output | 1 | One-cycle pulse when the chain ends |

## Verification
The bench's memory acknowledges every access in the cycle it is requested. This makes the busy time of every chain exactly the sum of 4 + 2n + 1 over its buffers, and the bench counts busy cycles from the falling clock edge after the start write. Both interrupt pulses appear in the cycle after the last write-back, the same sample in which `busy` is first seen low. The bench therefore counts them across that sample as well and checks, one sample later, that both have fallen. Memory images are compared only once the channel is idle. Setup writes made during a run, and the clear of the pending bit, are checked one cycle after they are applied.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_READ,
    SQ_WRITE,
    SQ_WBACK
  } sq_state_e;

  // descriptor word order in memory
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
  localparam int unsigned W_SRC      = 0;
  localparam int unsigned W_CTLA     = 1;
  localparam int unsigned W_CTLB     = 2;
  localparam int unsigned W_NEXT     = 3;

  // control B mode fields
  localparam int unsigned SMODE_LSB = 0;
  localparam int unsigned DMODE_LSB = 4;
  localparam logic [1:0]  AM_INC    = 2'd0;
  localparam logic [1:0]  AM_DEC    = 2'd1;

  // setup offsets
  localparam logic [1:0] CFG_DST   = 2'd0;
  localparam logic [1:0] CFG_START = 2'd1;
  localparam logic [1:0] CFG_CLR   = 2'd2;
endpackage

// File: rtl/lldma_step.sv
module lldma_step
  import lldma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic [DW-1:0] addr_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] addr_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_comb begin
    case (mode_i)
      AM_INC:  addr_o = addr_i + STEP_V;
      AM_DEC:  addr_o = addr_i - STEP_V;
      default: addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic             size_zero_i,
  input  logic             last_word_i,
  input  logic             next_zero_i,
  output sq_state_e        state_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  sq_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_FETCH;
          idx_d   = '0;
        end
      end
      SQ_FETCH: begin
        if (ack_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_d = size_zero_i ? SQ_WBACK : SQ_READ;
        end
      end
      SQ_READ: begin
        if (ack_i) state_d = SQ_WRITE;
      end
      SQ_WRITE: begin
        if (ack_i) state_d = last_word_i ? SQ_WBACK : SQ_READ;
      end
      SQ_WBACK: begin
        if (ack_i) begin
          state_d = next_zero_i ? SQ_IDLE : SQ_FETCH;
          idx_d   = '0;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  a_r9_fetch_follows_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WBACK && ack_i && !next_zero_i) |=> (state_q == SQ_FETCH && idx_q == '0));

  a_r3_fetch_holds_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FETCH && !ack_i) |=> $stable(idx_q));

  a_r10_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WBACK && ack_i && next_zero_i) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/lldma_irq.sv
module lldma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wb_done_i,
  input  logic last_i,
  input  logic clr_i,
  output logic buf_irq_o,
  output logic chain_irq_o,
  output logic pend_o
);
  logic buf_q, chain_q, pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (wb_done_i)  pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= 1'b0;
      chain_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      buf_q   <= wb_done_i;
      chain_q <= wb_done_i & last_i;
      pend_q  <= pend_d;
    end
  end

  assign buf_irq_o   = buf_q;
  assign chain_irq_o = chain_q;
  assign pend_o      = pend_q;

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    buf_q |=> !buf_q);

  a_r11_pend_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    buf_q |-> pend_q);

  a_r10_chain_single: assert property (@(posedge clk) disable iff (!rst_n)
    chain_q |=> !chain_q);
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          buf_irq,
  output logic          buf_pend,
  output logic          chain_irq
);
  localparam int            WORD_BYTES = DW / 8;
  localparam int            BSH        = $clog2(WORD_BYTES);
  localparam logic [DW-1:0] DONE_MASK  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CTLA_OFS   = DW'(W_CTLA) << BSH;
  localparam int            NPTR       = 2;  // 0 source, 1 destination

  // synchronous release of the asynchronous reset
  logic [1:0] rst_sync_q;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  sq_state_e        state;
  logic [IDX_W-1:0] idx;

  logic [DW-1:0] ptr_q, next_q, ctla_q, data_q;
  logic [1:0]    smode_q, dmode_q;
  logic [NPTR-1:0][DW-1:0] aptr_q, aptr_step;
  logic [NPTR-1:0][1:0]    amode;

  logic [SIZE_W-1:0] size_cur;
  logic start, clr, size_zero, last_word, next_zero, wb_done;
  logic fetch_ack, read_ack, write_ack;

  assign size_cur  = ctla_q[SIZE_W-1:0];
  assign size_zero = (size_cur == '0);
  assign last_word = (size_cur == SIZE_W'(1));
  assign next_zero = (next_q == '0);
  assign start     = cfg_we && (cfg_addr == CFG_START) && (state == SQ_IDLE);
  assign clr       = cfg_we && (cfg_addr == CFG_CLR) && cfg_wdata[0];
  assign fetch_ack = (state == SQ_FETCH) && mem_ack;
  assign read_ack  = (state == SQ_READ) && mem_ack;
  assign write_ack = (state == SQ_WRITE) && mem_ack;
  assign wb_done   = (state == SQ_WBACK) && mem_ack;
  assign busy      = (state != SQ_IDLE);

  assign amode[0] = smode_q;
  assign amode[1] = dmode_q;

  for (genvar g = 0; g < NPTR; g++) begin : g_step
    lldma_step #(.DW(DW), .STEP(WORD_BYTES)) i_step (
      .addr_i (aptr_q[g]),
      .mode_i (amode[g]),
      .addr_o (aptr_step[g])
    );
  end

  lldma_seq i_seq (
    .clk         (clk),
    .rst_n       (rst_in_n),
    .start_i     (start),
    .ack_i       (mem_ack),
    .size_zero_i (size_zero),
    .last_word_i (last_word),
    .next_zero_i (next_zero),
    .state_o     (state),
    .idx_o       (idx)
  );

  lldma_irq i_irq (
    .clk         (clk),
    .rst_n       (rst_in_n),
    .wb_done_i   (wb_done),
    .last_i      (next_zero),
    .clr_i       (clr),
    .buf_irq_o   (buf_irq),
    .chain_irq_o (chain_irq),
    .pend_o      (buf_pend)
  );

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      ptr_q   <= '0;
      next_q  <= '0;
      ctla_q  <= '0;
      data_q  <= '0;
      smode_q <= AM_INC;
      dmode_q <= AM_INC;
      aptr_q  <= '0;
    end else begin
      if (start) ptr_q <= cfg_wdata;
      else if (wb_done && !next_zero) ptr_q <= next_q;

      if (cfg_we && (cfg_addr == CFG_DST) && (state == SQ_IDLE)) aptr_q[1] <= cfg_wdata;
      else if (write_ack) aptr_q[1] <= aptr_step[1];

      if (fetch_ack && (idx == IDX_W'(W_SRC))) aptr_q[0] <= mem_rdata;
      else if (read_ack) aptr_q[0] <= aptr_step[0];

      if (fetch_ack && (idx == IDX_W'(W_CTLA))) ctla_q <= mem_rdata & ~DONE_MASK;
      else if (write_ack) ctla_q <= {ctla_q[DW-1:SIZE_W], size_cur - 1'b1};

      if (fetch_ack && (idx == IDX_W'(W_CTLB))) begin
        smode_q <= mem_rdata[SMODE_LSB +: 2];
        dmode_q <= mem_rdata[DMODE_LSB +: 2];
      end

      if (fetch_ack && (idx == IDX_W'(W_NEXT))) next_q <= mem_rdata;

      if (read_ack) data_q <= mem_rdata;
    end
  end

  // memory master outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      SQ_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + (DW'(idx) << BSH);
      end
      SQ_READ: begin
        mem_req  = 1'b1;
        mem_addr = aptr_q[0];
      end
      SQ_WRITE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = aptr_q[1];
        mem_wdata = data_q;
      end
      SQ_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + CTLA_OFS;
        mem_wdata = ctla_q | DONE_MASK;
      end
      default: ;
    endcase
  end

  a_r8_done_clear_in_flight: assert property (@(posedge clk) disable iff (!rst_in_n)
    (state == SQ_READ || state == SQ_WRITE) |-> !ctla_q[DW-1]);

  a_r7_wb_word_fields: assert property (@(posedge clk) disable iff (!rst_in_n)
    (state == SQ_WBACK) |-> (mem_we && mem_wdata[DW-1] && (mem_wdata[SIZE_W-1:0] == '0)));

  a_r2_dst_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_in_n)
    (busy && cfg_we && (cfg_addr == CFG_DST) && !write_ack) |=> $stable(aptr_q[1]));

  a_r4_idle_no_access: assert property (@(posedge clk) disable iff (!rst_in_n)
    !busy |-> !mem_req);

  a_r10_chain_ends_idle: assert property (@(posedge clk) disable iff (!rst_in_n)
    chain_irq |-> (buf_irq && !busy));
endmodule

// File: tb/test_lldma_chan.sv
module test_lldma_chan;
  logic        clk = 1'b0;
  logic        rst_n, cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, buf_irq, buf_pend, chain_irq;

  logic [31:0] mem  [256];
  logic [31:0] expm [256];
  logic        tb_we;
  logic [7:0]  tb_addr;
  logic [31:0] tb_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lldma_chan i_lldma_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .buf_irq(buf_irq),
    .buf_pend(buf_pend), .chain_irq(chain_irq)
  );

  // zero-wait memory
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (tb_we)        mem[tb_addr] <= tb_data;
  end

  // vector: [31:28] buffers, [25:24] src mode, [21:20] dst mode, [11:8],[7:4],[3:0] sizes
  localparam logic [31:0] VEC [6] = '{
    32'h1000_0005, 32'h2000_0340, 32'h3110_0235,
    32'h2200_0410, 32'h2020_0620, 32'h3000_0806
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int w, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 8'(w); tb_data = v;
    expm[w] = v;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int step_w(input int w, input logic [1:0] m);
    if (m == 2'd0)      return w + 1;
    else if (m == 2'd1) return w - 1;
    else                return w;
  endfunction

  task automatic run_vec(input logic [31:0] v, input bit poke_cfg, input string tag);
    int n, s, d, d0, tcyc, cycles, nb, nc, mism, base;
    int sz [3];
    logic [1:0] sm, dm;
    n  = int'(v[31:28]);
    sm = v[25:24];
    dm = v[21:20];
    for (int k = 0; k < 3; k++) sz[k] = int'(v[11-4*k -: 4]);
    for (int w = 0; w < 256; w++) poke(w, (w >= 32 && w < 80) ? (32'hC0DE_0000 | 32'(w)) : 32'h0);
    for (int k = 0; k < n; k++) begin
      base = 8 + 4 * k;
      s = 32 + 16 * k + ((sm == 2'd1) ? 7 : (sm == 2'd2) ? 3 : 0);
      poke(base, 32'(s * 4));
      poke(base + 1, 32'h8000_0000 | (32'(k + 1) << 16) | 32'(sz[k]));
      poke(base + 2, {26'h0, dm, 2'b00, sm});
      poke(base + 3, (k == n - 1) ? 32'h0 : 32'((base + 4) * 4));
    end
    @(negedge clk);
    tb_we = 1'b0;
    d0 = (dm == 2'd0) ? 96 : (dm == 2'd1) ? 127 : 100;
    d = d0; tcyc = 0;
    for (int k = 0; k < n; k++) begin
      base = 8 + 4 * k;
      s = 32 + 16 * k + ((sm == 2'd1) ? 7 : (sm == 2'd2) ? 3 : 0);
      for (int j = 0; j < sz[k]; j++) begin
        expm[d] = expm[s];
        s = step_w(s, sm);
        d = step_w(d, dm);
      end
      expm[base + 1] = 32'h8000_0000 | (32'(k + 1) << 16);
      tcyc += 5 + 2 * sz[k];
    end
    cfg_write(2'd0, 32'(d0 * 4));
    cfg_write(2'd1, 32'd32);
    cycles = 0; nb = 0; nc = 0;
    while (busy && cycles < 2000) begin
      cycles++;
      if (buf_irq) nb++;
      if (chain_irq) nc++;
      if (poke_cfg && cycles == 3) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'd800;
      end else if (poke_cfg && cycles == 4) begin
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h100;
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    if (buf_irq) nb++;
    if (chain_irq) nc++;
    check(!busy, {"R10 idle at end ", tag}, 32'(busy), 32'h0);
    check(cycles == tcyc, {"R9 busy cycles ", tag}, 32'(cycles), 32'(tcyc));
    check(nb == n, {"R11 buffer pulses ", tag}, 32'(nb), 32'(n));
    check(nc == 1, {"R10 chain pulses ", tag}, 32'(nc), 32'h1);
    @(negedge clk);
    check(!chain_irq && !buf_irq, {"R10 R11 pulses fall ", tag}, {30'h0, chain_irq, buf_irq}, 32'h0);
    mism = 0;
    for (int w = 0; w < 256; w++) if (mem[w] !== expm[w]) mism++;
    check(mism == 0, {"R3/R4/R5/R6 memory image ", tag}, 32'(mism), 32'h0);
    for (int k = 0; k < n; k++)
      check(mem[9 + 4 * k] === expm[9 + 4 * k], {"R7/R8 control A write-back ", tag},
            mem[9 + 4 * k], expm[9 + 4 * k]);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tb_we = 1'b0; tb_addr = '0; tb_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, mem_req, buf_irq, chain_irq, buf_pend} == 5'b0, "R1 reset outputs",
          {27'h0, busy, mem_req, buf_irq, chain_irq, buf_pend}, 32'h0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i], 1'b0, "vector");

    // R11 pending survives chained runs until cleared
    check(buf_pend, "R11 pending after run", 32'(buf_pend), 32'h1);
    cfg_write(2'd2, 32'h0);
    check(buf_pend, "R11 clear with bit0 low ignored", 32'(buf_pend), 32'h1);
    cfg_write(2'd2, 32'h1);
    check(!buf_pend, "R11 pending cleared", 32'(buf_pend), 32'h0);

    // R2 setup writes during a run have no effect
    run_vec(32'h1000_0005, 1'b1, "R2 writes while busy");
    check(mem[200] === 32'h0, "R2 no write at late destination", mem[200], 32'h0);

    // R4 single zero-size buffer: five busy cycles, no data
    run_vec(32'h1000_0000, 1'b0, "R4 zero size");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule